// File: doc/BRIEF.md
# Four-by-four bus crossbar with per-target arbitration

This block links four bus masters to four bus targets so that transfers aimed at different targets proceed in the same cycle. Each master presents a request with a 32-bit address, a write strobe and 32-bit write data, and it keeps all of them steady until it sees ready. The top address nibble selects the target. Each target has its own arbiter, and that arbiter's registered owner steers the address, write strobe and write data to the target. The target's read data and ready come back to the owner combinationally.

When several masters want the same target, a 2-bit priority per master picks the winner. Among masters tied at the top priority, the grant rotates, starting after the master most recently granted that target. The winner keeps the target until the target signals ready, and losing masters see a stall. Target 0 serves only master 0, the instruction-fetch master. An address outside the four targets completes at once with an error.

Top module: `xbar_fabric`

## Requirements
- R1: While reset is asserted and after it is released with no request pending, no target select is high and every master's ready, error and stall outputs are low.
- R2: Requests from different masters to different targets are served in the same cycles, so all four target selects can be high together.
- R3: Address bits [31:28] give the target index (0 to 3). A selected target sees its owner's address, write strobe and write data unchanged.
- R4: When several masters contend for an idle target, the master with the largest 2-bit priority value (m_prio bits [2m+1:2m]) is granted.
- R5: Masters tied at the largest priority are searched in increasing index order, wrapping around, starting from the index after the last master granted that target. After reset the last-granted index of every target is 3, so master 0 is searched first.
- R6: A grant is registered: it takes effect one clock after arbitration. It is held, even against a higher-priority request, until the target asserts ready, and the target can be re-granted in the next cycle.
- R7: A master's stall output is high exactly when its request is valid and it does not receive ready in that cycle.
- R8: The owning master receives its target's ready and read data in the same cycle. Every other master reads zero data with ready low.
- R9: A request whose address bits [31:28] are 4 or more gets ready and error in the same cycle with read data zero, and it never selects a target.
- R10: Target 0 is granted only to master 0. A request from any other master to target 0 stays stalled and never selects the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 4 | Request valid, one bit per master |
| m_addr | input | 128 | Master addresses, 32 bits per master, master m at [32m+31:32m] |
| m_we | input | 4 | Write strobe per master |
| m_wdata | input | 128 | Master write data, 32 bits per master |
| m_prio | input | 8 | Priority per master, 2 bits each, larger wins |
| m_wait | output | 4 | Stall per master |
| m_ready | output | 4 | Transfer complete per master |
| m_err | output | 4 | Decode-miss error per master |
| m_rdata | output | 128 | Read data per master |
| s_sel | output | 4 | Select per target |
| s_addr | output | 128 | Address per target |
| s_we | output | 4 | Write strobe per target |
| s_wdata | output | 128 | Write data per target |
| s_rdata | input | 128 | Read data from each target |
| s_ready | input | 4 | Ready from each target |

## Verification
The bound checker enforces several rules on every cycle. A stretched transfer must keep its address at the target. At most one master may complete per target in a cycle. Any ready without error must trace back to the target's ready, a decode miss must answer at once with zero data, and a master other than master 0 aimed at target 0 must stay stalled. Which master wins, the rotation order among tied masters, the refusal to pre-empt and true four-way concurrency depend on sequences of contending requests. Only the bench's scenarios and its per-cycle reference model, which predicts every select, ready, stall and data word, can show those.

// File: rtl/xbar_fabric.sv
`timescale 1ns/1ps
module xbar_fabric #(
  parameter int NM      = 4,
  parameter int NS      = 4,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int PW      = 2,
  parameter int SELW    = 4,
  parameter int FETCH_M = 0,
  parameter int FETCH_S = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NM-1:0]    m_req,
  input  logic [NM*AW-1:0] m_addr,
  input  logic [NM-1:0]    m_we,
  input  logic [NM*DW-1:0] m_wdata,
  input  logic [NM*PW-1:0] m_prio,
  output logic [NM-1:0]    m_wait,
  output logic [NM-1:0]    m_ready,
  output logic [NM-1:0]    m_err,
  output logic [NM*DW-1:0] m_rdata,
  output logic [NS-1:0]    s_sel,
  output logic [NS*AW-1:0] s_addr,
  output logic [NS-1:0]    s_we,
  output logic [NS*DW-1:0] s_wdata,
  input  logic [NS*DW-1:0] s_rdata,
  input  logic [NS-1:0]    s_ready
);
  localparam int IW = (NM > 1) ? $clog2(NM) : 1;
  localparam logic [SELW-1:0] NS_TOP = SELW'(NS);

  logic [SELW-1:0] tgt     [NM];
  logic [NM-1:0]   miss;
  logic [NM-1:0]   cand    [NS];
  logic            own_v   [NS];
  logic [IW-1:0]   own_id  [NS];
  logic [IW-1:0]   last_id [NS];
  logic            win_v   [NS];
  logic [IW-1:0]   win_id  [NS];

  for (genvar m = 0; m < NM; m++) begin : g_dec
    assign tgt[m]  = m_addr[m*AW+AW-1 -: SELW];
    assign miss[m] = m_req[m] && (tgt[m] >= NS_TOP);
  end

  for (genvar s = 0; s < NS; s++) begin : g_port
    for (genvar m = 0; m < NM; m++) begin : g_cand
      assign cand[s][m] = m_req[m] && (tgt[m] == SELW'(s)) && (s != FETCH_S || m == FETCH_M);
    end

    always_comb begin
      logic [IW-1:0] idx;
      logic [PW-1:0] best;
      logic          found;
      found = 1'b0;
      best  = '0;
      idx   = '0;
      win_id[s] = last_id[s];
      for (int k = 1; k <= NM; k++) begin
        idx = IW'((int'(last_id[s]) + k) % NM);
        if (cand[s][idx] && (!found || m_prio[idx*PW +: PW] > best)) begin
          found     = 1'b1;
          best      = m_prio[idx*PW +: PW];
          win_id[s] = idx;
        end
      end
      win_v[s] = found;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        own_v[s]   <= 1'b0;
        own_id[s]  <= '0;
        last_id[s] <= IW'(NM-1);
      end else if (own_v[s]) begin
        if (!s_sel[s] || s_ready[s]) own_v[s] <= 1'b0;
      end else if (win_v[s]) begin
        own_v[s]   <= 1'b1;
        own_id[s]  <= win_id[s];
        last_id[s] <= win_id[s];
      end
    end

    assign s_sel[s]              = own_v[s] && m_req[own_id[s]];
    assign s_we[s]               = s_sel[s] && m_we[own_id[s]];
    assign s_addr[s*AW +: AW]    = m_addr[own_id[s]*AW +: AW];
    assign s_wdata[s*DW +: DW]   = m_wdata[own_id[s]*DW +: DW];
  end

  always_comb begin
    m_ready = '0;
    m_err   = '0;
    m_rdata = '0;
    for (int m = 0; m < NM; m++) begin
      if (miss[m]) begin
        m_ready[m] = 1'b1;
        m_err[m]   = 1'b1;
      end else begin
        for (int s = 0; s < NS; s++) begin
          if (s_sel[s] && own_id[s] == IW'(m) && tgt[m] == SELW'(s)) begin
            m_ready[m]           = s_ready[s];
            m_rdata[m*DW +: DW]  = s_rdata[s*DW +: DW];
          end
        end
      end
    end
  end

  assign m_wait = m_req & ~m_ready;
endmodule

module xbar_fabric_chk #(
  parameter int NM      = 4,
  parameter int NS      = 4,
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int SELW    = 4,
  parameter int FETCH_M = 0,
  parameter int FETCH_S = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NM-1:0]    m_req,
  input logic [NM*AW-1:0] m_addr,
  input logic [NM-1:0]    m_wait,
  input logic [NM-1:0]    m_ready,
  input logic [NM-1:0]    m_err,
  input logic [NM*DW-1:0] m_rdata,
  input logic [NS-1:0]    s_sel,
  input logic [NS-1:0]    s_ready,
  input logic [NS*AW-1:0] s_addr
);
  localparam int SW = (NS > 1) ? $clog2(NS) : 1;
  logic [SELW-1:0] tgt   [NM];
  logic [NM-1:0]   hit_s [NS];

  for (genvar m = 0; m < NM; m++) begin : g_m
    assign tgt[m] = m_addr[m*AW+AW-1 -: SELW];

    p_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (m_req[m] && tgt[m] >= SELW'(NS)) |-> (m_ready[m] && m_err[m] && m_rdata[m*DW +: DW] == '0));

    p_ready_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (m_ready[m] && !m_err[m]) |-> (tgt[m] < SELW'(NS) && s_ready[tgt[m][SW-1:0]]));

    if (m != FETCH_M) begin : g_res
      p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req[m] && tgt[m] == SELW'(FETCH_S)) |-> (m_wait[m] && !m_ready[m]));
    end
  end

  for (genvar s = 0; s < NS; s++) begin : g_s
    for (genvar m = 0; m < NM; m++) begin : g_h
      assign hit_s[s][m] = m_ready[m] && !m_err[m] && tgt[m] == SELW'(s);
    end

    p_one_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hit_s[s]) <= 1);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (s_sel[s] && !s_ready[s]) |=> (!s_sel[s] || $stable(s_addr[s*AW +: AW])));
  end
endmodule

bind xbar_fabric xbar_fabric_chk #(
  .NM(NM), .NS(NS), .AW(AW), .DW(DW), .SELW(SELW), .FETCH_M(FETCH_M), .FETCH_S(FETCH_S)
) u_chk (
  .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_addr(m_addr), .m_wait(m_wait),
  .m_ready(m_ready), .m_err(m_err), .m_rdata(m_rdata), .s_sel(s_sel),
  .s_ready(s_ready), .s_addr(s_addr)
);

// File: tb/sim_xbar_fabric.sv
`timescale 1ns/1ps
module sim_xbar_fabric;
  localparam int NM = 4, NS = 4, AW = 32, DW = 32, PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NM-1:0]    req = '0, we = '0;
  logic [AW-1:0]    addr [NM];
  logic [DW-1:0]    wd   [NM];
  logic [PW-1:0]    pr   [NM];
  logic [NM*AW-1:0] m_addr;
  logic [NM*DW-1:0] m_wdata, m_rdata;
  logic [NM*PW-1:0] m_prio;
  logic [NM-1:0]    m_wait, m_ready, m_err;
  logic [NS-1:0]    s_sel, s_we, s_ready;
  logic [NS*AW-1:0] s_addr;
  logic [NS*DW-1:0] s_wdata, s_rdata;

  int lat [NS];
  int cnt [NS];

  for (genvar m = 0; m < NM; m++) begin : g_pack
    assign m_addr[m*AW +: AW]  = addr[m];
    assign m_wdata[m*DW +: DW] = wd[m];
    assign m_prio[m*PW +: PW]  = pr[m];
  end
  for (genvar s = 0; s < NS; s++) begin : g_slv
    assign s_ready[s]          = s_sel[s] && (cnt[s] >= lat[s]);
    assign s_rdata[s*DW +: DW] = ~s_addr[s*AW +: AW] ^ DW'(s);
  end

  xbar_fabric u0 (
    .clk(clk), .rst_n(rst_n), .m_req(req), .m_addr(m_addr), .m_we(we),
    .m_wdata(m_wdata), .m_prio(m_prio), .m_wait(m_wait), .m_ready(m_ready),
    .m_err(m_err), .m_rdata(m_rdata), .s_sel(s_sel), .s_addr(s_addr),
    .s_we(s_we), .s_wdata(s_wdata), .s_rdata(s_rdata), .s_ready(s_ready)
  );

  int tests = 0, fails = 0;
  int own [NS], last [NS], nown [NS], nlast [NS];
  logic [AW-1:0] mq [NM][$];
  bit nreq [NM];
  logic [AW-1:0] naddr [NM];
  bit abort_m [NM];
  string ord [NS];
  int errs [NM];
  int all4 = 0;

  task automatic chk(bit ok, string tag, string what);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s", tag, what);
    end
  endtask

  initial begin
    for (int i = 0; i < NS; i++) begin
      own[i] = -1; last[i] = NM-1; nown[i] = -1; nlast[i] = NM-1;
      lat[i] = 0; cnt[i] = 0; ord[i] = "";
    end
    for (int i = 0; i < NM; i++) begin
      addr[i] = '0; wd[i] = '0; pr[i] = '0; nreq[i] = 0; naddr[i] = '0;
      abort_m[i] = 0; errs[i] = 0;
    end
  end

  always @(posedge clk)
    for (int s = 0; s < NS; s++)
      cnt[s] <= (!s_sel[s] || s_ready[s]) ? 0 : cnt[s] + 1;

  // reference model and master drivers: evaluate at the falling edge
  always @(negedge clk) begin
    int tg [NM];
    bit ms [NM];
    bit esel [NS];
    bit er, ee, ew;
    logic [DW-1:0] ed;
    int best, i;
    if (!rst_n)
      for (int s = 0; s < NS; s++) begin own[s] = -1; last[s] = NM-1; end
    for (int m = 0; m < NM; m++) begin
      tg[m] = int'(addr[m][31:28]);
      ms[m] = req[m] && tg[m] >= NS;
    end
    for (int s = 0; s < NS; s++) begin
      esel[s] = (own[s] >= 0) ? req[own[s]] : 1'b0;
      chk(s_sel[s] == esel[s], "R6",
          $sformatf("s_sel[%0d] act=%0b exp=%0b", s, s_sel[s], esel[s]));
      if (esel[s])
        chk(s_addr[s*AW +: AW] == addr[own[s]] && s_we[s] == we[own[s]] &&
            s_wdata[s*DW +: DW] == wd[own[s]], "R3",
            $sformatf("target %0d addr act=%h exp=%h", s, s_addr[s*AW +: AW], addr[own[s]]));
    end
    for (int m = 0; m < NM; m++) begin
      er = 0; ee = 0; ed = '0;
      if (ms[m]) begin
        er = 1; ee = 1;
      end else if (req[m] && tg[m] < NS) begin
        if (own[tg[m]] == m && esel[tg[m]]) begin
          er = s_ready[tg[m]];
          ed = ~addr[m] ^ DW'(tg[m]);
        end
      end
      ew = req[m] && !er;
      chk(m_ready[m] == er && m_err[m] == ee && m_rdata[m*DW +: DW] == ed,
          ms[m] ? "R9" : "R8",
          $sformatf("master %0d rdy/err/data act=%0b/%0b/%h exp=%0b/%0b/%h",
                    m, m_ready[m], m_err[m], m_rdata[m*DW +: DW], er, ee, ed));
      chk(m_wait[m] == ew, "R7",
          $sformatf("master %0d wait act=%0b exp=%0b", m, m_wait[m], ew));
      if (rst_n && m_ready[m] && !m_err[m] && tg[m] < NS)
        ord[tg[m]] = {ord[tg[m]], $sformatf("%0d", m)};
      if (rst_n && m_ready[m] && m_err[m]) errs[m]++;
    end
    if (s_sel == '1) all4++;
    for (int s = 0; s < NS; s++) begin
      nown[s] = own[s]; nlast[s] = last[s];
      if (rst_n) begin
        if (own[s] >= 0) begin
          if (!esel[s] || s_ready[s]) nown[s] = -1;
        end else begin
          best = -1;
          for (int k = 1; k <= NM; k++) begin
            i = (last[s] + k) % NM;
            if (req[i] && !ms[i] && tg[i] == s && (s != 0 || i == 0))
              if (best < 0 || pr[i] > pr[best]) best = i;
          end
          if (best >= 0) begin nown[s] = best; nlast[s] = best; end
        end
      end
    end
    for (int m = 0; m < NM; m++) begin
      nreq[m] = req[m]; naddr[m] = addr[m];
      if (!rst_n || abort_m[m]) nreq[m] = 0;
      else if (!req[m] || m_ready[m]) begin
        if (mq[m].size() > 0) begin
          naddr[m] = mq[m].pop_front();
          nreq[m] = 1;
        end else nreq[m] = 0;
      end
    end
  end

  always @(posedge clk) begin
    #1;
    for (int s = 0; s < NS; s++) begin own[s] = nown[s]; last[s] = nlast[s]; end
    for (int m = 0; m < NM; m++) begin
      req[m]  = nreq[m];
      addr[m] = naddr[m];
      we[m]   = naddr[m][2];
      wd[m]   = naddr[m] ^ 32'h1357_9BDF;
    end
  end

  task automatic do_reset(input logic [PW-1:0] p0, p1, p2, p3);
    @(posedge clk); #1.5;
    rst_n = 1'b0;
    pr[0] = p0; pr[1] = p1; pr[2] = p2; pr[3] = p3;
    for (int s = 0; s < NS; s++) begin lat[s] = 0; ord[s] = ""; end
    for (int m = 0; m < NM; m++) begin mq[m].delete(); errs[m] = 0; abort_m[m] = 0; end
    all4 = 0;
    repeat (2) @(posedge clk);
    #1.5 rst_n = 1'b1;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    do begin
      @(posedge clk); #2;
      n++;
    end while (!(mq[0].size() == 0 && mq[1].size() == 0 && mq[2].size() == 0 &&
                 mq[3].size() == 0 && req == '0) && n < 500);
    repeat (2) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired before the scenarios ended");
    finish_run();
  end

  initial begin
    do_reset(0, 0, 0, 0);
    @(negedge clk); #0.5;
    chk(s_sel == '0 && m_ready == '0 && m_wait == '0 && m_err == '0, "R1",
        $sformatf("idle outputs sel=%b rdy=%b wait=%b err=%b exp all zero", s_sel, m_ready, m_wait, m_err));

    // R2: one master per target, all at once
    do_reset(0, 0, 0, 0);
    for (int s = 0; s < NS; s++) lat[s] = 2;
    mq[0].push_back(32'h0000_0100);
    mq[1].push_back(32'h1000_0104);
    mq[2].push_back(32'h2000_0200);
    mq[3].push_back(32'h3000_0304);
    wait_idle();
    chk(all4 > 0, "R2", $sformatf("cycles with all selects act=%0d exp>0", all4));
    for (int s = 0; s < NS; s++)
      chk(ord[s] == $sformatf("%0d", s), "R3", $sformatf("target %0d order act=%s exp=%0d", s, ord[s], s));

    // R4: priority 1 < 2 < 3 on target 1
    do_reset(0, 1, 3, 2);
    lat[1] = 1;
    mq[1].push_back(32'h1000_0010);
    mq[2].push_back(32'h1000_0020);
    mq[3].push_back(32'h1000_0034);
    wait_idle();
    chk(ord[1] == "231", "R4", $sformatf("order act=%s exp=231", ord[1]));

    // R5: equal priority rotation from reset value of last grant
    do_reset(0, 0, 0, 0);
    for (int m = 1; m < NM; m++) begin
      mq[m].push_back(32'h2000_0000 | (m << 4));
      mq[m].push_back(32'h2000_0104 | (m << 4));
    end
    wait_idle();
    chk(ord[2] == "123123", "R5", $sformatf("order act=%s exp=123123", ord[2]));

    // R4 with R5: tied top level rotates, lower level waits
    do_reset(1, 2, 2, 2);
    lat[3] = 1;
    for (int m = 0; m < NM; m++) begin
      mq[m].push_back(32'h3000_0000 | (m << 8));
      mq[m].push_back(32'h3000_0084 | (m << 8));
    end
    wait_idle();
    chk(ord[3] == "12312300", "R4", $sformatf("mixed order act=%s exp=12312300", ord[3]));
    chk(ord[3] == "12312300", "R5", $sformatf("tie rotation act=%s exp=12312300", ord[3]));

    // R6: no pre-emption by a later higher-priority request
    do_reset(0, 0, 0, 3);
    lat[1] = 4;
    mq[1].push_back(32'h1000_0040);
    repeat (3) @(posedge clk);
    mq[3].push_back(32'h1000_0080);
    repeat (3) @(posedge clk);
    @(negedge clk); #0.5;
    chk(m_wait[3] == 1'b1 && s_sel[1] == 1'b1 && s_addr[AW +: AW] == 32'h1000_0040, "R6",
        $sformatf("while held wait3=%0b sel1=%0b addr=%h exp 1/1/10000040", m_wait[3], s_sel[1], s_addr[AW +: AW]));
    wait_idle();
    chk(ord[1] == "13", "R6", $sformatf("order act=%s exp=13", ord[1]));

    // R10: target 0 reserved for master 0
    do_reset(0, 0, 3, 0);
    lat[0] = 3;
    mq[2].push_back(32'h0000_0040);
    mq[0].push_back(32'h0000_0010);
    mq[0].push_back(32'h0000_0024);
    begin
      int n;
      n = 0;
      do begin @(posedge clk); #2; n++; end while ((mq[0].size() != 0 || req[0]) && n < 200);
    end
    repeat (4) @(posedge clk);
    @(negedge clk); #0.5;
    chk(ord[0] == "00", "R10", $sformatf("target 0 order act=%s exp=00", ord[0]));
    chk(req[2] == 1'b1 && m_wait[2] == 1'b1 && s_sel[0] == 1'b0, "R10",
        $sformatf("master 2 req=%0b wait=%0b sel0=%0b exp 1/1/0", req[2], m_wait[2], s_sel[0]));
    abort_m[2] = 1;
    wait_idle();
    abort_m[2] = 0;

    // R9: decode miss alongside a normal transfer
    do_reset(0, 0, 0, 0);
    lat[2] = 1;
    mq[1].push_back(32'h5000_0010);
    mq[3].push_back(32'hF000_0004);
    mq[2].push_back(32'h2000_0008);
    wait_idle();
    chk(errs[1] == 1 && errs[3] == 1 && errs[2] == 0, "R9",
        $sformatf("error counts act=%0d/%0d/%0d exp=1/1/0", errs[1], errs[3], errs[2]));
    chk(ord[2] == "2", "R9", $sformatf("normal transfer beside miss act=%s exp=2", ord[2]));

    finish_run();
  end
endmodule